// File: doc/BRIEF.md
# Texture Level-of-Detail Calculator

This block turns a raw fixed-point level-of-detail (LOD) value into the three quantities a mip-mapped texture sampler needs. It produces a clamped mip level index, an 8-bit interpolation fraction between two adjacent levels, and a flag that tells whether the LOD reaches 1.0. The raw LOD is a 17-bit two's-complement number with 5 fractional bits, so 1.0 is 0x0020. A floor given in the same format and a ceiling given as a level index bound the result. The level index is the position of the leading one of the clamped LOD. The fraction is read from the bits just below that leading one.

Two modes change the fraction. Sharpen mode negates the fraction for LODs below 1.0. When neither sharpen nor detail mode is on, the fraction is pinned at the two limits of the mip range. The work is spread over three register stages. Alongside the pipeline the block gives out the load flag delayed by three and by four clocks. It also produces a cycle signal from a small state machine. On a span-start strobe that machine enters CYC_LOW, then alternates CYC_HIGH and CYC_LOW. It parks in CYC_PARKED instead when the sampled cycle count is zero. Transitions: any state to CYC_LOW on a start with nonzero count; any state to CYC_PARKED on a start with zero count; CYC_LOW to CYC_HIGH and CYC_HIGH to CYC_LOW otherwise; CYC_PARKED holds. Reset enters CYC_PARKED.

Top module: `lod_calc`

## Requirements
- R1: A raw LOD above 0x7FFF (positive, bit 15 or 16 pattern with bit 16 clear) is treated as 0x7FFF.
- R2: A raw LOD that is negative (bit 16 set) or smaller than `lod_min` is replaced by `lod_min`.
- R3: For a clamped LOD of at least 0x0020, the level index is floor(log2(clamped/32)). Below 0x0020 it is 0, and `level_o` shows it unless R4 applies.
- R4: The max condition holds when the clamped LOD is at least 0x2000 (256.0), or when it is at least 1.0 and the level index is at least `level_max`. When it holds, `level_o` equals `level_max`.
- R5: The raw fraction is the 8 bits directly below the leading one of the clamped LOD, left-justified, with zeros filled in below bit 0. A clamped LOD of zero gives a fraction of zero.
- R6: With both `sharpen_en` and `detail_en` low, the fraction is 0xFF under the max condition and 0x00 when the clamped LOD is below 1.0. In every other case the fraction passes through unchanged.
- R7: When `sharpen_en` is high and the clamped LOD is below 1.0, `frac_o` (9-bit two's complement) is the negation of the fraction. Otherwise it is the fraction zero-extended.
- R8: `ge_one_o` is high exactly when the clamped LOD is at least 0x0020.
- R9: `load_d3_o` and `load_d4_o` equal `load` as sampled 3 and 4 clock edges earlier.
- R10: The clock edge after a sampled `span_start` leaves `cycle_o` low. It then inverts on every edge while the count sampled with the start was nonzero. With a zero count it stays low until the next start.
- R11: `level_o`, `frac_o` and `ge_one_o` reflect the inputs sampled three clock edges earlier.
- R12: Asynchronous active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lod_raw | input | 17 | Raw LOD, two's complement, 5 fractional bits |
| lod_min | input | 15 | Lower LOD bound, same format, unsigned |
| level_max | input | 3 | Highest mip level index allowed |
| sharpen_en | input | 1 | Sharpen mode enable |
| detail_en | input | 1 | Detail mode enable |
| load | input | 1 | Load flag, delayed to the outputs |
| span_start | input | 1 | Span-start strobe for the cycle generator |
| ncyc | input | 4 | Cycle count, sampled with `span_start` |
| level_o | output | 3 | Clamped mip level index |
| frac_o | output | 9 | Signed interpolation fraction |
| ge_one_o | output | 1 | Clamped LOD is at least 1.0 |
| load_d3_o | output | 1 | `load` delayed by three clocks |
| load_d4_o | output | 1 | `load` delayed by four clocks |
| cycle_o | output | 1 | Alternating cycle signal |

## Verification
The stimulus goes after the clamp boundaries. These are raw values just above 0x7FFF, negative values, and values a step below and above `lod_min` and 1.0. A wrong clamp shows up there as a level index or fraction taken from the unclamped number. The stimulus also drives LODs at exact powers of two and at 0x2000, and sets `level_max` equal to the computed index. A leading-one finder that is off by one, or a max test using the wrong inequality, then returns the wrong level or a fraction that is not forced. Every combination of sharpen and detail is crossed with LODs below 1.0 and at the maximum, so a missing negation or a forcing that ignores the modes changes `frac_o`. Span starts with a zero count and back-to-back starts expose a cycle generator that keeps toggling or misses its restart.

// File: rtl/lod_pkg.sv
package lod_pkg;

    // States of the alternating cycle generator
    typedef enum logic [1:0] {
        CYC_PARKED = 2'd0,
        CYC_LOW    = 2'd1,
        CYC_HIGH   = 2'd2
    } cyc_state_e;

endpackage

// File: rtl/lod_lead_one.sv
module lod_lead_one #(
    parameter int W  = 15,
    parameter int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [PW-1:0] pos
);

    // Highest set bit wins; an all-zero vector reports position 0
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = PW'(i);
        end
    end

endmodule

// File: rtl/lod_delay_line.sv
module lod_delay_line #(
    parameter int DEPTH = 4,
    parameter int TAP   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic tap_o,
    output logic last_o
);

    logic [DEPTH-1:0] stage_q;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= 1'b0;
                    else        stage_q[g] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= 1'b0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign tap_o  = stage_q[TAP-1];
    assign last_o = stage_q[DEPTH-1];

endmodule

// File: rtl/lod_cycle_fsm.sv
module lod_cycle_fsm
    import lod_pkg::*;
#(
    parameter int NCYC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              span_start,
    input  logic [NCYC_W-1:0] ncyc,
    output logic              cycle_o
);

    cyc_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CYC_PARKED;
        else        state_q <= state_d;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (span_start) begin
            state_d = (ncyc == '0) ? CYC_PARKED : CYC_LOW;
        end else begin
            unique case (state_q)
                CYC_PARKED: state_d = CYC_PARKED;
                CYC_LOW:    state_d = CYC_HIGH;
                CYC_HIGH:   state_d = CYC_LOW;
                default:    state_d = CYC_PARKED;
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            CYC_HIGH: cycle_o = 1'b1;
            default:  cycle_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/lod_calc.sv
module lod_calc
    import lod_pkg::*;
#(
    parameter int LOD_W      = 15,
    parameter int FRAC_BITS  = 5,
    parameter int FRAC_OUT_W = 8,
    parameter int IDX_W      = 3,
    parameter int NCYC_W     = 4,
    parameter int LOAD_DLY_A = 3,
    parameter int LOAD_DLY_B = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LOD_W+1:0]        lod_raw,
    input  logic [LOD_W-1:0]        lod_min,
    input  logic [IDX_W-1:0]        level_max,
    input  logic                    sharpen_en,
    input  logic                    detail_en,
    input  logic                    load,
    input  logic                    span_start,
    input  logic [NCYC_W-1:0]       ncyc,
    output logic [IDX_W-1:0]        level_o,
    output logic [FRAC_OUT_W:0]     frac_o,
    output logic                    ge_one_o,
    output logic                    load_d3_o,
    output logic                    load_d4_o,
    output logic                    cycle_o
);

    localparam int POS_W   = $clog2(LOD_W);
    localparam int EXT_W   = LOD_W + FRAC_OUT_W;
    localparam int TOP_SH  = (1 << IDX_W) + FRAC_BITS;
    localparam logic [LOD_W-1:0] LOD_ONE = {{(LOD_W-1){1'b0}}, 1'b1} << FRAC_BITS;
    localparam logic [LOD_W-1:0] LOD_TOP = {{(LOD_W-1){1'b0}}, 1'b1} << TOP_SH;

    // ---------------- stage A: clamp ----------------
    logic [LOD_W-1:0] clamp_c;
    logic [LOD_W-1:0] a_clamp_q;
    logic             a_sharp_q, a_detail_q;
    logic [IDX_W-1:0] a_lmax_q;

    always_comb begin
        if (lod_raw[LOD_W+1])                    clamp_c = lod_min;
        else if (lod_raw[LOD_W])                 clamp_c = '1;
        else if (lod_raw[LOD_W-1:0] < lod_min)   clamp_c = lod_min;
        else                                     clamp_c = lod_raw[LOD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_clamp_q  <= '0;
            a_sharp_q  <= 1'b0;
            a_detail_q <= 1'b0;
            a_lmax_q   <= '0;
        end else begin
            a_clamp_q  <= clamp_c;
            a_sharp_q  <= sharpen_en;
            a_detail_q <= detail_en;
            a_lmax_q   <= level_max;
        end
    end

    // ---------------- stage B: level, flags, raw fraction ----------------
    logic [POS_W-1:0]      lead_pos;
    logic [POS_W-1:0]      idx_full;
    logic                  b_min_c, b_max_c;
    logic [IDX_W-1:0]      b_idx_c;
    logic [FRAC_OUT_W-1:0] b_frac_c;
    logic [EXT_W-1:0]      frac_ext;

    logic                  b_min_q, b_max_q, b_ge_q, b_sharp_q, b_detail_q;
    logic [IDX_W-1:0]      b_idx_q;
    logic [FRAC_OUT_W-1:0] b_frac_q;

    lod_lead_one #(.W(LOD_W), .PW(POS_W)) i_lead (
        .vec (a_clamp_q),
        .pos (lead_pos)
    );

    always_comb begin
        b_min_c  = (a_clamp_q < LOD_ONE);
        idx_full = lead_pos - POS_W'(FRAC_BITS);
        b_max_c  = (a_clamp_q >= LOD_TOP) ||
                   (!b_min_c && (idx_full >= POS_W'(a_lmax_q)));
        if (b_max_c)      b_idx_c = a_lmax_q;
        else if (b_min_c) b_idx_c = '0;
        else              b_idx_c = idx_full[IDX_W-1:0];
        frac_ext = {a_clamp_q, {FRAC_OUT_W{1'b0}}} >> lead_pos;
        b_frac_c = frac_ext[FRAC_OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_min_q    <= 1'b0;
            b_max_q    <= 1'b0;
            b_ge_q     <= 1'b0;
            b_sharp_q  <= 1'b0;
            b_detail_q <= 1'b0;
            b_idx_q    <= '0;
            b_frac_q   <= '0;
        end else begin
            b_min_q    <= b_min_c;
            b_max_q    <= b_max_c;
            b_ge_q     <= !b_min_c;
            b_sharp_q  <= a_sharp_q;
            b_detail_q <= a_detail_q;
            b_idx_q    <= b_idx_c;
            b_frac_q   <= b_frac_c;
        end
    end

    // ---------------- stage C: forcing and sign ----------------
    logic [FRAC_OUT_W-1:0] fc_c;
    logic [FRAC_OUT_W:0]   fsigned_c;

    always_comb begin
        if (b_sharp_q || b_detail_q) fc_c = b_frac_q;
        else if (b_max_q)            fc_c = '1;
        else if (b_min_q)            fc_c = '0;
        else                         fc_c = b_frac_q;
        if (b_min_q && b_sharp_q) fsigned_c = ~{1'b0, fc_c} + 1'b1;
        else                      fsigned_c = {1'b0, fc_c};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_o  <= '0;
            frac_o   <= '0;
            ge_one_o <= 1'b0;
        end else begin
            level_o  <= b_idx_q;
            frac_o   <= fsigned_c;
            ge_one_o <= b_ge_q;
        end
    end

    // ---------------- side paths ----------------
    lod_delay_line #(.DEPTH(LOAD_DLY_B), .TAP(LOAD_DLY_A)) i_load_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (load),
        .tap_o  (load_d3_o),
        .last_o (load_d4_o)
    );

    lod_cycle_fsm #(.NCYC_W(NCYC_W)) i_cyc (
        .clk        (clk),
        .rst_n      (rst_n),
        .span_start (span_start),
        .ncyc       (ncyc),
        .cycle_o    (cycle_o)
    );

endmodule

// File: rtl/lod_calc_chk.sv
module lod_calc_chk #(
    parameter int IDX_W      = 3,
    parameter int FRAC_OUT_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                load,
    input logic                span_start,
    input logic [IDX_W-1:0]    level_o,
    input logic [FRAC_OUT_W:0] frac_o,
    input logic                ge_one_o,
    input logic                load_d3_o,
    input logic                load_d4_o,
    input logic                cycle_o
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_d4_follows_d3_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1) |-> (load_d4_o == $past(load_d3_o)));

    assert_d3_tracks_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (load_d3_o == $past(load, 3)));

    assert_cycle_alternates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_o |=> !cycle_o);

    assert_start_lowers_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        span_start |=> !cycle_o);

    assert_negative_below_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frac_o[FRAC_OUT_W] |-> !ge_one_o);

    assert_level_zero_below_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ge_one_o |-> (level_o == '0));

endmodule

bind lod_calc lod_calc_chk #(.IDX_W(IDX_W), .FRAC_OUT_W(FRAC_OUT_W)) i_lod_calc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .span_start (span_start),
    .level_o    (level_o),
    .frac_o     (frac_o),
    .ge_one_o   (ge_one_o),
    .load_d3_o  (load_d3_o),
    .load_d4_o  (load_d4_o),
    .cycle_o    (cycle_o)
);

// File: tb/test_lod_calc.sv
module test_lod_calc;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [16:0] lod_raw = '0;
    logic [14:0]        lod_min = '0;
    logic [2:0]         level_max = '0;
    logic               sharpen_en = 1'b0, detail_en = 1'b0, load = 1'b0, span_start = 1'b0;
    logic [3:0]         ncyc = '0;
    logic [2:0]         level_o;
    logic [8:0]         frac_o;
    logic               ge_one_o, load_d3_o, load_d4_o, cycle_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;

    always #4 clk = ~clk;

    lod_calc i_lod_calc (
        .clk(clk), .rst_n(rst_n), .lod_raw(lod_raw), .lod_min(lod_min),
        .level_max(level_max), .sharpen_en(sharpen_en), .detail_en(detail_en),
        .load(load), .span_start(span_start), .ncyc(ncyc),
        .level_o(level_o), .frac_o(frac_o), .ge_one_o(ge_one_o),
        .load_d3_o(load_d3_o), .load_d4_o(load_d4_o), .cycle_o(cycle_o)
    );

    typedef struct {
        int    lvl;
        int    frac;
        int    ge;
        string ltag;
        string ftag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   h1, h2, h3, h4;
    int   cyc_e;
    bit   tog;

    function automatic exp_t model(int raw, int mn, int mx, bit sh, bit de);
        exp_t e;
        int c, idx, t, pw, fr, fc;
        bit mnf, mxf, to_min;
        to_min = 0;
        if (raw > 32767) c = 32767;
        else if (raw < 0 || raw < mn) begin c = mn; to_min = 1; end
        else c = raw;
        mnf = (c < 32);
        idx = 0;
        if (!mnf) begin
            t = c / 32;
            while (t >= 2) begin t = t / 2; idx++; end
        end
        mxf = (c >= 8192) || (!mnf && idx >= mx);
        e.lvl = mxf ? mx : (mnf ? 0 : idx);
        if (c == 0) fr = 0;
        else begin
            pw = 1;
            while (pw * 2 <= c) pw = pw * 2;
            fr = (c * 256) / pw - 256;
        end
        if (sh || de) fc = fr;
        else if (mxf) fc = 255;
        else if (mnf) fc = 0;
        else fc = fr;
        e.frac = (mnf && sh) ? -fc : fc;
        e.ge   = mnf ? 0 : 1;
        if (raw > 32767)  e.ltag = "R1";
        else if (to_min)  e.ltag = "R2";
        else if (mxf)     e.ltag = "R4";
        else              e.ltag = "R3";
        if (mnf && sh)                  e.ftag = "R7";
        else if (!sh && !de && (mnf || mxf)) e.ftag = "R6";
        else                            e.ftag = "R5";
        return e;
    endfunction

    function automatic exp_t zero_entry();
        exp_t e;
        e.lvl = 0; e.frac = 0; e.ge = 0; e.ltag = "R12"; e.ftag = "R12";
        return e;
    endfunction

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            q.push_back(zero_entry());
            q.push_back(zero_entry());
            cur = zero_entry();
            h1 = 0; h2 = 0; h3 = 0; h4 = 0;
            cyc_e = 0; tog = 0;
        end else begin
            q.push_back(model(int'(lod_raw), int'(lod_min), int'(level_max), sharpen_en, detail_en));
            cur = q.pop_front();
            h4 = h3; h3 = h2; h2 = h1; h1 = int'(load);
            if (span_start) begin
                cyc_e = 0;
                tog = (ncyc != 0);
            end else if (tog) begin
                cyc_e = 1 - cyc_e;
            end
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // Compare away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && cmp_en) begin
            check(cur.ltag, "level (R11 latency)", int'(level_o), cur.lvl);
            check(cur.ftag, "fraction", int'($signed(frac_o)), cur.frac);
            check("R8", "ge_one", int'(ge_one_o), cur.ge);
            check("R9", "load_d3", int'(load_d3_o), h3);
            check("R9", "load_d4", int'(load_d4_o), h4);
            check("R10", "cycle", int'(cycle_o), cyc_e);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic drive(int raw, int mn, int mx, bit sh, bit de, bit ld, bit ss, int nc);
        @(negedge clk);
        lod_raw    = 17'(raw);
        lod_min    = 15'(mn);
        level_max  = 3'(mx);
        sharpen_en = sh;
        detail_en  = de;
        load       = ld;
        span_start = ss;
        ncyc       = 4'(nc);
    endtask

    initial begin
        int dir[] = '{0, 1, 31, 32, 33, 63, 64, 100, 255, 256, 4095, 8191, 8192,
                      32767, 32768, 65535, -1, -32768, 48, 1000};
        repeat (3) @(negedge clk);
        // R12: outputs cleared during reset
        check("R12", "level in reset", int'(level_o), 0);
        check("R12", "frac in reset", int'(frac_o), 0);
        check("R12", "cycle in reset", int'(cycle_o), 0);
        check("R12", "load_d4 in reset", int'(load_d4_o), 0);
        rst_n  = 1'b1;
        cmp_en = 1'b1;
        // R1, R2, R3, R5, R6, R7: directed corners under every mode mix
        for (int m = 0; m < 4; m++) begin
            foreach (dir[i]) drive(dir[i], 0, 7, m[0], m[1], i[0], 0, 1);
            foreach (dir[i]) drive(dir[i], 40, 3, m[0], m[1], 0, 0, 1);
        end
        // R4: level_max equal to, below and above computed index
        for (int mx = 0; mx < 8; mx++) begin
            drive(64, 0, mx, 0, 0, 1, 0, 0);
            drive(1024, 0, mx, 0, 0, 0, 0, 0);
            drive(8191, 0, mx, 1, 0, 1, 0, 0);
        end
        // R2: around the floor
        drive(99, 100, 7, 0, 0, 0, 0, 0);
        drive(100, 100, 7, 0, 0, 0, 0, 0);
        drive(101, 100, 7, 1, 0, 0, 0, 0);
        drive(5, 20, 7, 1, 0, 0, 0, 0);
        drive(-5, 20, 7, 1, 1, 0, 0, 0);
        // R10: start with zero count, back-to-back starts, restart
        drive(50, 0, 7, 0, 0, 0, 1, 0);
        repeat (5) drive(50, 0, 7, 0, 0, 0, 0, 0);
        drive(50, 0, 7, 0, 0, 0, 1, 3);
        repeat (5) drive(50, 0, 7, 0, 0, 0, 0, 0);
        drive(50, 0, 7, 0, 0, 1, 1, 3);
        drive(50, 0, 7, 0, 0, 1, 1, 3);
        drive(50, 0, 7, 0, 0, 0, 0, 0);
        drive(50, 0, 7, 0, 0, 0, 1, 0);
        repeat (4) drive(50, 0, 7, 0, 0, 0, 0, 0);
        // Mixed traffic
        for (int n = 0; n < 3000; n++) begin
            int r, mn;
            case ($urandom % 4)
                0: r = int'($urandom_range(0, 300));
                1: r = int'($urandom_range(0, 65535));
                2: r = -int'($urandom_range(1, 65536));
                default: r = int'($urandom_range(0, 32767));
            endcase
            mn = ($urandom % 4 == 0) ? int'($urandom_range(0, 200)) : 0;
            drive(r, mn, int'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom),
                  ($urandom % 8 == 0), int'($urandom % 3));
        end
        repeat (6) drive(0, 0, 0, 0, 0, 0, 0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule